// File: doc/BRIEF.md
# Sub-frame Stream Lock and Error Monitor

This block sits behind a biphase decoder of a two-channel digital audio receiver and watches the decoded stream. It takes one-cycle strobes for frame preambles, block preambles, sub-frame ends and biphase violations, together with the payload bits of each finished sub-frame. From these it keeps a lock state and a set of sticky error flags.

Lock is only granted after a fixed run of frame preambles, followed by a block preamble. While locked, a frame timer counts system clocks between preambles. A run of timer expiries with no preamble in between takes the lock away. Each error flag stays set until a clear request arrives. The current status is also given as one 3-bit code, in which loss of lock outranks every flag.

The output port reports slipped samples on its own strobe. Those strobes only count while the port's frame sync and bit clock are inputs. An external channel-status checker reports CRC failures on a separate strobe.

Top module: `rxm_lock_monitor`

## Requirements
- R1: From the acquiring state, lock is granted only after ACQ_FRAMES (3) frame preambles and then a block preamble. `locked_o` rises on the clock edge that samples the block preamble strobe.
- R2: A block preamble that arrives before the third frame preamble has been counted restarts the frame count from zero.
- R3: While unlocked, FRAME_TMO system clocks without any preamble restart acquisition from zero frames.
- R4: While locked, each span of FRAME_TMO clocks without a preamble counts as one missed preamble, and any preamble resets that count. After MISS_LIMIT (4) consecutive misses, `locked_o` falls.
- R5: At a sub-frame end, the parity flag is set if the number of ones in `sf_data_i` is odd.
- R6: A biphase violation strobe sets the coding flag.
- R7: At a sub-frame end, the validity flag is set if `sf_data_i[VLD_POS]` (bit 24 by default) is high.
- R8: A slip strobe sets the slip flag only while `port_slave_i` is high. Otherwise it has no effect.
- R9: A CRC failure strobe sets the CRC flag.
- R10: Flags are sticky, and `clr_err_i` clears them all on the next edge. An event sampled together with the clear still sets its flag, and the clear leaves lock untouched. Flag bits are: [4] coding, [3] parity, [2] slip, [1] CRC, [0] validity.
- R11: `err_code_o` is 6 when unlocked. When locked it is the highest-ranked set flag: coding 5, parity 4, slip 3, CRC 2, validity 1. It is 0 when no flag is set.
- R12: After synchronous reset the block is unlocked, all flags are clear, and the code is 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_pre_i | input | 1 | Frame preamble strobe |
| blk_pre_i | input | 1 | Block preamble strobe |
| sf_end_i | input | 1 | Sub-frame complete strobe |
| sf_data_i | input | SF_BITS | Payload bits of the finished sub-frame, parity bit included |
| bp_viol_i | input | 1 | Biphase coding violation strobe |
| slip_i | input | 1 | Slipped-sample strobe from the output port |
| port_slave_i | input | 1 | Output port sync and bit clock are inputs |
| crc_fail_i | input | 1 | Channel-status CRC failure strobe |
| clr_err_i | input | 1 | Clear all sticky flags |
| locked_o | output | 1 | Lock state |
| err_code_o | output | 3 | Priority-encoded status code |
| err_flags_o | output | 5 | Sticky flags |

## Verification
All state is registered, so every result is due on the first clock edge after the strobe that causes it. This includes lock rising after a block preamble, a flag set or cleared, and lock falling on the fourth timer expiry. The code follows the registers with no further delay. The bench drives inputs on the falling edge and advances its behavioural model at the same rising edge the design uses. It compares lock, flags and code one time unit after each rising edge. It also makes explicit checks on the ports at the points each requirement names.

// File: rtl/rxm_pkg.sv
// Shared types for the lock and error monitor.
// Assumes: codes rise with priority; no-lock is the largest code.
package rxm_pkg;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_ARM   = 2'd1,
        ST_LOCK  = 2'd2
    } lock_st_t;

    typedef struct packed {
        logic coding;
        logic parity;
        logic slip;
        logic crc;
        logic valid;
    } err_flags_t;

    localparam logic [2:0] CODE_NONE   = 3'd0;
    localparam logic [2:0] CODE_VALID  = 3'd1;
    localparam logic [2:0] CODE_CRC    = 3'd2;
    localparam logic [2:0] CODE_SLIP   = 3'd3;
    localparam logic [2:0] CODE_PARITY = 3'd4;
    localparam logic [2:0] CODE_CODING = 3'd5;
    localparam logic [2:0] CODE_NOLOCK = 3'd6;

endpackage

// File: rtl/rxm_pre_timer.sv
// Frame timer. Counts system clocks since the last preamble of either
// kind and pulses expire_o when FRAME_TMO clocks pass without one.
// After each expiry it restarts.
// Assumes: FRAME_TMO >= 2 and strobes last one clock.
module rxm_pre_timer #(
    parameter int FRAME_TMO = 192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pre_i,
    output logic expire_o
);
    localparam int TMR_W = $clog2(FRAME_TMO + 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(FRAME_TMO - 1);

    logic [TMR_W-1:0] tmr_q;

    // Expiry when the last count is reached and no preamble rescues it
    assign expire_o = !pre_i && (tmr_q == TMR_LAST);

    // Count clocks, restarting on a preamble or on expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (pre_i || expire_o) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_q + 1'b1;
        end
    end

    AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q <= TMR_LAST);                                   // R3
    AST_TMR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        pre_i |=> (tmr_q == '0));                             // R4

endmodule

// File: rtl/rxm_lock_fsm.sv
// Lock state machine.
// Acquiring: counts frame preambles, and a block preamble restarts the count.
// After ACQ_FRAMES frames it waits for a block preamble and then locks.
// A timer expiry while unlocked restarts acquisition.
// While locked, MISS_LIMIT consecutive timer expiries drop the lock.
// Assumes: a simultaneous block and frame strobe counts as a block.
module rxm_lock_fsm
    import rxm_pkg::*;
#(
    parameter int ACQ_FRAMES = 3,
    parameter int MISS_LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frm_pre_i,
    input  logic blk_pre_i,
    input  logic expire_i,
    output logic locked_o
);
    localparam int ACQ_W  = $clog2(ACQ_FRAMES + 1);
    localparam int MISS_W = $clog2(MISS_LIMIT + 1);
    localparam logic [ACQ_W-1:0]  ACQ_LAST  = ACQ_W'(ACQ_FRAMES - 1);
    localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(MISS_LIMIT - 1);

    lock_st_t          st_q, st_d;
    logic [ACQ_W-1:0]  acq_q, acq_d;
    logic [MISS_W-1:0] miss_q, miss_d;

    // Next-state logic for acquisition, lock hold and lock loss
    always_comb begin
        st_d   = st_q;
        acq_d  = acq_q;
        miss_d = miss_q;
        unique case (st_q)
            ST_HUNT: begin
                if (blk_pre_i) begin
                    acq_d = '0;
                end else if (frm_pre_i) begin
                    if (acq_q == ACQ_LAST) begin
                        st_d  = ST_ARM;
                        acq_d = '0;
                    end else begin
                        acq_d = acq_q + 1'b1;
                    end
                end else if (expire_i) begin
                    acq_d = '0;
                end
            end
            ST_ARM: begin
                if (blk_pre_i) begin
                    st_d   = ST_LOCK;
                    miss_d = '0;
                end else if (!frm_pre_i && expire_i) begin
                    st_d  = ST_HUNT;
                    acq_d = '0;
                end
            end
            ST_LOCK: begin
                if (frm_pre_i || blk_pre_i) begin
                    miss_d = '0;
                end else if (expire_i) begin
                    if (miss_q == MISS_LAST) begin
                        st_d   = ST_HUNT;
                        acq_d  = '0;
                        miss_d = '0;
                    end else begin
                        miss_d = miss_q + 1'b1;
                    end
                end
            end
            default: begin
                st_d   = ST_HUNT;
                acq_d  = '0;
                miss_d = '0;
            end
        endcase
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_HUNT;
            acq_q  <= '0;
            miss_q <= '0;
        end else begin
            st_q   <= st_d;
            acq_q  <= acq_d;
            miss_q <= miss_d;
        end
    end

    assign locked_o = (st_q == ST_LOCK);

    AST_LOCK_VIA_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(blk_pre_i));                // R1
    AST_DROP_ON_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && expire_i && (miss_q == MISS_LAST)) |=> !locked_o); // R4
    AST_HOLD_ON_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && (frm_pre_i || blk_pre_i)) |=> locked_o); // R4

endmodule

// File: rtl/rxm_err_flags.sv
// Sticky error flags. Each flag is set by its event and held until a
// clear. An event sampled in the same clock as the clear still sets
// its flag.
// Assumes: sf_data_i is valid while sf_end_i is high.
module rxm_err_flags
    import rxm_pkg::*;
#(
    parameter int SF_BITS = 28,
    parameter int VLD_POS = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sf_end_i,
    input  logic [SF_BITS-1:0] sf_data_i,
    input  logic               bp_viol_i,
    input  logic               slip_i,
    input  logic               port_slave_i,
    input  logic               crc_fail_i,
    input  logic               clr_i,
    output err_flags_t         flags_o
);
    err_flags_t ev, held;

    // Collect this clock's events
    always_comb begin
        ev.coding = bp_viol_i;
        ev.parity = sf_end_i && (^sf_data_i);
        ev.slip   = slip_i && port_slave_i;
        ev.crc    = crc_fail_i;
        ev.valid  = sf_end_i && sf_data_i[VLD_POS];
    end

    // Keep the old flags unless a clear is requested
    assign held = clr_i ? '0 : flags_o;

    // Flag register: held value merged with new events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_o <= '0;
        end else begin
            flags_o <= held | ev;
        end
    end

    AST_PARITY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (sf_end_i && (^sf_data_i)) |=> flags_o.parity);       // R5
    AST_CODING_SET: assert property (@(posedge clk) disable iff (!rst_n)
        bp_viol_i |=> flags_o.coding);                        // R6
    AST_SLIP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_slave_i && !clr_i) |=> (flags_o.slip == $past(flags_o.slip))); // R8
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !sf_end_i && !bp_viol_i && !slip_i && !crc_fail_i)
        |=> (flags_o == '0));                                 // R10

endmodule

// File: rtl/rxm_err_encode.sv
// Priority encoder from the lock state and the flags to the 3-bit code.
// Assumes: the code values in rxm_pkg rise with priority.
module rxm_err_encode
    import rxm_pkg::*;
(
    input  logic       locked_i,
    input  err_flags_t flags_i,
    output logic [2:0] code_o
);
    // Highest-ranked condition wins
    always_comb begin
        if (!locked_i)            code_o = CODE_NOLOCK;
        else if (flags_i.coding)  code_o = CODE_CODING;
        else if (flags_i.parity)  code_o = CODE_PARITY;
        else if (flags_i.slip)    code_o = CODE_SLIP;
        else if (flags_i.crc)     code_o = CODE_CRC;
        else if (flags_i.valid)   code_o = CODE_VALID;
        else                      code_o = CODE_NONE;
    end

endmodule

// File: rtl/rxm_lock_monitor.sv
// Top level of the lock and error monitor. It joins the frame timer,
// the lock state machine, the sticky flags and the code encoder.
// Assumes: all inputs are synchronous to clk and strobes last one clock.
module rxm_lock_monitor
    import rxm_pkg::*;
#(
    parameter int SF_BITS    = 28,
    parameter int VLD_POS    = 24,
    parameter int FRAME_TMO  = 192,
    parameter int ACQ_FRAMES = 3,
    parameter int MISS_LIMIT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frm_pre_i,
    input  logic               blk_pre_i,
    input  logic               sf_end_i,
    input  logic [SF_BITS-1:0] sf_data_i,
    input  logic               bp_viol_i,
    input  logic               slip_i,
    input  logic               port_slave_i,
    input  logic               crc_fail_i,
    input  logic               clr_err_i,
    output logic               locked_o,
    output logic [2:0]         err_code_o,
    output logic [4:0]         err_flags_o
);
    logic       any_pre;
    logic       expire;
    err_flags_t flags;

    assign any_pre = frm_pre_i || blk_pre_i;

    rxm_pre_timer #(.FRAME_TMO(FRAME_TMO)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .pre_i    (any_pre),
        .expire_o (expire)
    );

    rxm_lock_fsm #(.ACQ_FRAMES(ACQ_FRAMES), .MISS_LIMIT(MISS_LIMIT)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_pre_i (frm_pre_i),
        .blk_pre_i (blk_pre_i),
        .expire_i  (expire),
        .locked_o  (locked_o)
    );

    rxm_err_flags #(.SF_BITS(SF_BITS), .VLD_POS(VLD_POS)) u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .sf_end_i     (sf_end_i),
        .sf_data_i    (sf_data_i),
        .bp_viol_i    (bp_viol_i),
        .slip_i       (slip_i),
        .port_slave_i (port_slave_i),
        .crc_fail_i   (crc_fail_i),
        .clr_i        (clr_err_i),
        .flags_o      (flags)
    );

    rxm_err_encode u_enc (
        .locked_i (locked_o),
        .flags_i  (flags),
        .code_o   (err_code_o)
    );

    assign err_flags_o = flags;

    AST_NOLOCK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        !locked_o |-> (err_code_o == CODE_NOLOCK));           // R11
    AST_CLEAR_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_err_i && locked_o && any_pre) |=> locked_o);     // R10

endmodule

// File: tb/rxm_lock_monitor_tb.sv
// Bench: behavioural reference model advanced at every rising edge and
// compared with the design one time unit later.
module rxm_lock_monitor_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SFB  = 28;
    localparam int VPOS = 24;
    localparam int TMO  = 16;
    localparam int ACQ  = 3;
    localparam int MISS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frm = 1'b0, blk = 1'b0, sfe = 1'b0, viol = 1'b0;
    logic slip = 1'b0, slave = 1'b0, crc = 1'b0, clr = 1'b0;
    logic [SFB-1:0] data = '0;
    logic       locked;
    logic [2:0] code;
    logic [4:0] flags;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit auto_pre = 1'b0;

    // reference model state
    int m_state = 0;   // 0 acquiring, 1 waiting for block, 2 locked
    int m_cnt = 0, m_tmr = 0, m_miss = 0;
    bit [4:0] m_flags = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxm_lock_monitor #(.SF_BITS(SFB), .VLD_POS(VPOS), .FRAME_TMO(TMO),
                       .ACQ_FRAMES(ACQ), .MISS_LIMIT(MISS)) u_dut (
        .clk(clk), .rst_n(rst_n), .frm_pre_i(frm), .blk_pre_i(blk),
        .sf_end_i(sfe), .sf_data_i(data), .bp_viol_i(viol), .slip_i(slip),
        .port_slave_i(slave), .crc_fail_i(crc), .clr_err_i(clr),
        .locked_o(locked), .err_code_o(code), .err_flags_o(flags));

    function automatic int m_code();
        if (m_state != 2) return 6;
        if (m_flags[4]) return 5;
        if (m_flags[3]) return 4;
        if (m_flags[2]) return 3;
        if (m_flags[1]) return 2;
        if (m_flags[0]) return 1;
        return 0;
    endfunction

    task automatic check(input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", what, act, exp, cyc);
        end
    endtask

    // advance the model with the inputs that the coming edge samples
    task automatic model_step();
        bit pre, exp_hit;
        int ones;
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_tmr = 0; m_miss = 0; m_flags = '0;
            return;
        end
        pre = frm || blk;
        exp_hit = !pre && (m_tmr == TMO - 1);
        if (m_state == 0) begin
            if (blk) m_cnt = 0;
            else if (frm) begin
                m_cnt++;
                if (m_cnt == ACQ) begin m_state = 1; m_cnt = 0; end
            end else if (exp_hit) m_cnt = 0;
        end else if (m_state == 1) begin
            if (blk) begin m_state = 2; m_miss = 0; end
            else if (exp_hit) begin m_state = 0; m_cnt = 0; end
        end else begin
            if (pre) m_miss = 0;
            else if (exp_hit) begin
                m_miss++;
                if (m_miss == MISS) begin m_state = 0; m_cnt = 0; m_miss = 0; end
            end
        end
        m_tmr = (pre || exp_hit) ? 0 : m_tmr + 1;
        if (clr) m_flags = '0;
        ones = 0;
        for (int i = 0; i < SFB; i++) ones += int'(data[i]);
        if (viol) m_flags[4] = 1'b1;
        if (sfe && (ones % 2 == 1)) m_flags[3] = 1'b1;
        if (slip && slave) m_flags[2] = 1'b1;
        if (crc) m_flags[1] = 1'b1;
        if (sfe && data[VPOS]) m_flags[0] = 1'b1;
    endtask

    // one clock: drive at the falling edge, compare after the rising edge
    task automatic step();
        if (auto_pre && (cyc % 8 == 0) && !blk) frm = 1'b1;
        model_step();
        @(posedge clk);
        #1;
        cyc++;
        check(int'(locked), (m_state == 2) ? 1 : 0, "R1 R2 R3 R4 lock");
        check(int'(flags), int'(m_flags), "R5 R6 R7 R8 R9 R10 flags");
        check(int'(code), m_code(), "R11 code");
        @(negedge clk);
        frm = 0; blk = 0; sfe = 0; viol = 0; slip = 0; crc = 0; clr = 0;
        data = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic pre_frame(); frm = 1'b1; step(); idle(2); endtask
    task automatic pre_block(); blk = 1'b1; step(); endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        idle(3);
        rst_n = 1'b1;
        // R12: reset state
        check(int'(locked), 0, "R12 locked after reset");
        check(int'(code), 6, "R12 code after reset");
        check(int'(flags), 0, "R12 flags after reset");

        // R2: early block restarts count
        pre_frame(); pre_frame(); pre_block(); idle(1);
        pre_frame(); pre_frame(); pre_block();
        check(int'(locked), 0, "R2 no lock after restart");
        // R1: three frames then block
        pre_frame(); pre_frame(); pre_frame(); idle(3); pre_block();
        check(int'(locked), 1, "R1 lock after sequence");

        auto_pre = 1'b1;
        // R5 parity
        sfe = 1; data = 28'h1; step();
        check(int'(code), 4, "R5 parity code");
        // R6 coding outranks parity
        viol = 1; step();
        check(int'(code), 5, "R6 coding code");
        clr = 1; step();
        check(int'(code), 0, "R10 cleared code");
        // R7 validity with even parity
        sfe = 1; data = (28'h1 << VPOS) | 28'h1; step();
        check(int'(code), 1, "R7 validity code");
        // R8 slip ignored while port is master
        slave = 0; slip = 1; step();
        check(int'(flags), 5'b00001, "R8 slip ignored");
        slave = 1; slip = 1; step();
        check(int'(code), 3, "R8 slip code");
        slave = 0;
        // R9 CRC
        crc = 1; step();
        check(int'(code), 3, "R11 slip outranks crc");
        clr = 1; step();
        crc = 1; step();
        check(int'(code), 2, "R9 crc code");
        // R10 event with clear wins, lock unaffected
        clr = 1; viol = 1; step();
        check(int'(flags), 5'b10000, "R10 event with clear");
        clr = 1; step();
        check(int'(flags), 0, "R10 clear");
        check(int'(locked), 1, "R10 lock kept");

        // R4 misses reset by a preamble
        auto_pre = 1'b0;
        idle(3 * TMO + 4);
        check(int'(locked), 1, "R4 three misses keep lock");
        frm = 1; step();
        idle(3 * TMO + 4);
        check(int'(locked), 1, "R4 miss count reset");
        idle(TMO);
        check(int'(locked), 0, "R4 lock lost");
        check(int'(code), 6, "R11 nolock code");

        // R3 timeout restarts acquisition
        pre_frame(); pre_frame(); idle(TMO + 2); pre_frame(); pre_block();
        check(int'(locked), 0, "R3 timeout restart");
        pre_frame(); pre_frame(); pre_frame(); pre_block();
        check(int'(locked), 1, "R3 relock");
        idle(4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule